// File: doc/BRIEF.md
# Color memory-LCD source timing generator

This block produces the horizontal side of a 6-bit-color memory LCD interface. It drives three kinds of output:

- a double-edged source clock;
- a group start pulse;
- a 6-bit pixel bus carrying two bits each of red, green and blue.

Every edge of the source clock samples one new pixel value. A group consists of a fixed number of data half-periods followed by a fixed number of zero-data half-periods. Groups run back to back with no gap, and a frame ends with one extra group whose pixel data is all zero.

The block runs from a `tick` enable that marks one quarter of a source-clock half-period, so all clock and start-pulse edges fall on tick boundaries. A one-cycle `start` from the gate timing logic launches a frame.

Pixel bytes come in on a valid/ready stream, and only the low six bits of each byte reach the bus. If a byte is due and the stream is not valid, the block freezes its outputs until data arrives, and it records the event in a sticky flag. Once the last group ends, the outputs return low and the block waits for the next `start`.

Top module: `lcd_src_timing`

## Requirements
- R1: Synchronous reset drives `bck`, `bsp`, `pix_bus`, `pix_ready` and `underrun` to 0, and the block then waits for `start`. It asserts `pix_ready` for no tick until a frame is launched.
- R2: `start` is accepted on any clock cycle while idle. `bsp` rises 2 ticks after it is accepted, and `bck` rises, beginning half-period 1, 2 ticks after that.
- R3: Without a stall, every source-clock half-period lasts exactly 4 ticks. `bck` is high in odd half-periods and low in even ones, and it changes only on a tick.
- R4: `bsp` rises while `bck` is low and stays high for exactly 8 ticks. It starts 2 ticks before half-period 1 and falls at the midpoint of half-period 2.
- R5: In half-periods 1 to `DATA_HP` of a data group, each half-period presents a freshly accepted stream byte on `pix_bus`, as bits 5:0 of the byte in arrival order. Bits 7:6 are ignored. `pix_bus` changes only together with a `bck` edge, and `pix_ready` is asserted only on a tick at a boundary where a byte is due.
- R6: In half-periods `DATA_HP+1` to `DATA_HP+TAIL_HP` of every group, `pix_bus` is 0.
- R7: Groups follow each other without a gap. The next `bsp` rises 2 ticks before the end of the previous group's last half-period, and the next half-period 1 begins on the following boundary.
- R8: A frame holds `GROUPS` groups: `bsp` rises `GROUPS` times and `bck` makes `GROUPS*(DATA_HP+TAIL_HP)` edges. The last group carries all-zero data and accepts no stream bytes, so a frame accepts exactly `(GROUPS-1)*DATA_HP` bytes.
- R9: After the last half-period of a frame, `bck`, `bsp` and `pix_bus` are 0 and stay 0 until the next `start`. A `start` that arrives during a frame has no effect.
- R10: If a byte is due on a tick and `pix_valid` is 0, then `bck`, `bsp` and `pix_bus` hold their values and `underrun` is set. `underrun` stays at 1 until reset, and the frame continues normally once `pix_valid` returns.
- R11: A reset in the middle of a frame returns all outputs to 0 and clears `underrun`. A following `start` runs a complete frame with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable, one per quarter of a source-clock half-period |
| start | input | 1 | One-cycle frame launch from the gate timing side |
| pix_data | input | BYTE_W | Pixel byte; low PIX_W bits used |
| pix_valid | input | 1 | Stream byte valid |
| pix_ready | output | 1 | Stream byte taken this cycle when valid |
| bck | output | 1 | Double-edged source clock |
| bsp | output | 1 | Group start pulse |
| pix_bus | output | PIX_W | Pixel data to the panel |
| underrun | output | 1 | Sticky flag: a byte was due while the stream was empty |

## Verification
The bench feeds bytes of several kinds through a small instance of three groups:

- bytes with every bit set, used to find stuck-low lines;
- zero bytes and bytes with only the top two bits set, used to show that bits 7:6 never reach the bus;
- alternating patterns, used to separate swapped or shifted bit slices;
- a distinct value in every slot, used to expose skipped, repeated or reordered bytes across group boundaries.

Three other runs stress the frame timing. One frame holds the stream empty at its first boundary, which separates a real stall from a slip or a dropped byte. Another frame includes a stray `start` in its middle. A third run resets partway through a frame and then launches a fresh one, which shows whether the block re-arms or keeps stale counts.

// File: rtl/lcd_src_pkg.sv
package lcd_src_pkg;

    // Sequencer phase: idle, the lead-in before the first group, and groups.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Ticks per source-clock half-period and the quarter index width.
    localparam int QTR_PER_HP = 4;
    localparam int QTR_W      = $clog2(QTR_PER_HP);
    localparam logic [QTR_W-1:0] QTR_MID  = QTR_W'(QTR_PER_HP / 2);
    localparam logic [QTR_W-1:0] QTR_LAST = QTR_W'(QTR_PER_HP - 1);

    // Counter widths for half-period-in-group and group-in-frame.
    localparam int HP_W  = 16;
    localparam int GRP_W = 16;

    // Position of the sequencer within a frame.
    typedef struct packed {
        phase_e             phase;
        logic [QTR_W-1:0]   qtr;
        logic [HP_W-1:0]    hp;   // 1-based half-period inside the group
        logic [GRP_W-1:0]   grp;  // 1-based group inside the frame
    } src_pos_t;

    // Per-cycle strobes from the sequencer.
    typedef struct packed {
        logic boundary;  // a new half-period begins at this edge
        logic due;       // that half-period takes a stream byte
        logic finish;    // the frame ends at this edge
    } src_evt_t;

    localparam src_pos_t POS_IDLE = '{phase: PH_IDLE, qtr: '0, hp: '0, grp: '0};

    // Group start pulse level: last half of the lead-in or of the closing
    // half-period of a non-final group, all of half-period 1, and the first
    // half of half-period 2.
    function automatic logic bsp_level(input src_pos_t p,
                                       input logic [HP_W-1:0] hpg,
                                       input logic [GRP_W-1:0] ngrp);
        logic late;
        late = (p.qtr >= QTR_MID);
        case (p.phase)
            PH_LEAD: return late;
            PH_RUN:  return (p.hp == HP_W'(1))
                         || ((p.hp == HP_W'(2)) && !late)
                         || ((p.hp == hpg) && late && (p.grp != ngrp));
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_src_seq.sv
module lcd_src_seq
    import lcd_src_pkg::*;
#(
    parameter int DATA_HP = 120,
    parameter int TAIL_HP = 4,
    parameter int GROUPS  = 641
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     start,
    input  logic     stall,
    output src_pos_t pos,
    output src_evt_t evt
);

    localparam int HP_GRP = DATA_HP + TAIL_HP;
    localparam logic [HP_W-1:0]  HPG_V  = HP_W'(HP_GRP);
    localparam logic [HP_W-1:0]  DATA_V = HP_W'(DATA_HP);
    localparam logic [GRP_W-1:0] GRP_V  = GRP_W'(GROUPS);

    logic             running;
    logic             at_qlast;
    logic             last_hp;
    logic             last_grp;
    logic [HP_W-1:0]  nxt_hp;
    logic [GRP_W-1:0] nxt_grp;

    always_comb begin
        running  = (pos.phase == PH_RUN);
        at_qlast = (pos.qtr == QTR_LAST);
        last_hp  = (pos.hp == HPG_V);
        last_grp = (pos.grp == GRP_V);

        if (pos.phase == PH_LEAD) begin
            nxt_hp  = HP_W'(1);
            nxt_grp = GRP_W'(1);
        end else if (last_hp) begin
            nxt_hp  = HP_W'(1);
            nxt_grp = pos.grp + GRP_W'(1);
        end else begin
            nxt_hp  = pos.hp + HP_W'(1);
            nxt_grp = pos.grp;
        end

        evt.finish   = tick && running && at_qlast && last_hp && last_grp;
        evt.boundary = tick && at_qlast
                    && ((pos.phase == PH_LEAD) || (running && !(last_hp && last_grp)));
        // The closing group of a frame carries no stream data.
        evt.due      = evt.boundary && (nxt_hp <= DATA_V) && (nxt_grp < GRP_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= POS_IDLE;
        end else if (pos.phase == PH_IDLE) begin
            if (start) begin
                pos.phase <= PH_LEAD;
                pos.qtr   <= '0;
                pos.hp    <= '0;
                pos.grp   <= '0;
            end
        end else if (tick && !stall) begin
            if (!at_qlast) begin
                pos.qtr <= pos.qtr + QTR_W'(1);
            end else if (evt.finish) begin
                pos <= POS_IDLE;
            end else begin
                pos.phase <= PH_RUN;
                pos.qtr   <= '0;
                pos.hp    <= nxt_hp;
                pos.grp   <= nxt_grp;
            end
        end
    end

endmodule

// File: rtl/lcd_src_wave.sv
module lcd_src_wave
    import lcd_src_pkg::*;
#(
    parameter int HP_GRP = 124,
    parameter int GROUPS = 641
) (
    input  src_pos_t pos,
    output logic     bck,
    output logic     bsp
);

    localparam logic [HP_W-1:0]  HPG_V = HP_W'(HP_GRP);
    localparam logic [GRP_W-1:0] GRP_V = GRP_W'(GROUPS);

    // HP_GRP is even, so half-period 1 of every group is a high level.
    always_comb begin
        bck = (pos.phase == PH_RUN) && pos.hp[0];
        bsp = bsp_level(pos, HPG_V, GRP_V);
    end

endmodule

// File: rtl/lcd_src_pixel.sv
module lcd_src_pixel
    import lcd_src_pkg::*;
#(
    parameter int PIX_W  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  src_evt_t          evt,
    input  logic [BYTE_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              stall,
    output logic [PIX_W-1:0]  pix_bus,
    output logic              underrun
);

    logic accept;
    logic unused_hi;

    generate
        if (BYTE_W > PIX_W) begin : g_drop_hi
            assign unused_hi = ^pix_data[BYTE_W-1:PIX_W];
        end else begin : g_no_hi
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_comb begin
        pix_ready = evt.due;
        accept    = evt.due && pix_valid;
        stall     = evt.due && !pix_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_bus  <= '0;
            underrun <= 1'b0;
        end else begin
            if (accept) begin
                pix_bus <= pix_data[PIX_W-1:0];
            end else if ((evt.boundary && !evt.due) || evt.finish) begin
                pix_bus <= '0;
            end
            if (stall) begin
                underrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_src_timing.sv
module lcd_src_timing
    import lcd_src_pkg::*;
#(
    parameter int DATA_HP = 120,
    parameter int TAIL_HP = 4,
    parameter int GROUPS  = 641,
    parameter int PIX_W   = 6,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              bck,
    output logic              bsp,
    output logic [PIX_W-1:0]  pix_bus,
    output logic              underrun
);

    localparam int HP_GRP = DATA_HP + TAIL_HP;

    src_pos_t pos;
    src_evt_t evt;
    logic     stall;

    lcd_src_seq #(
        .DATA_HP (DATA_HP),
        .TAIL_HP (TAIL_HP),
        .GROUPS  (GROUPS)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (start),
        .stall (stall),
        .pos   (pos),
        .evt   (evt)
    );

    lcd_src_wave #(
        .HP_GRP (HP_GRP),
        .GROUPS (GROUPS)
    ) u_wave (
        .pos (pos),
        .bck (bck),
        .bsp (bsp)
    );

    lcd_src_pixel #(
        .PIX_W  (PIX_W),
        .BYTE_W (BYTE_W)
    ) u_pix (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .stall     (stall),
        .pix_bus   (pix_bus),
        .underrun  (underrun)
    );

endmodule

// File: rtl/lcd_src_timing_chk.sv
module lcd_src_timing_chk #(
    parameter int PIX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             bck,
    input logic             bsp,
    input logic [PIX_W-1:0] pix_bus,
    input logic             underrun
);

    // R1: one cycle after reset everything is low
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> (!bck && !bsp && (pix_bus == '0) && !underrun && !pix_ready));

    // R3: the source clock only moves on a tick
    a_r3_bck_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (bck != $past(bck))) |-> $past(tick));

    // R4: the group start pulse rises while the source clock is low
    a_r4_bsp_rise_bck_low: assert property (@(posedge clk) disable iff (rst)
        $rose(bsp) |-> !bck);

    // R5: a byte is requested only on a tick
    a_r5_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> tick);

    // R5: the pixel bus changes only together with a source-clock edge
    a_r5_bus_on_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (pix_bus != $past(pix_bus))) |-> (bck != $past(bck)));

    // R10: an empty stream at a due boundary freezes the outputs and flags it
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (pix_ready && !pix_valid) |=> ($stable(bck) && $stable(bsp) && $stable(pix_bus) && underrun));

    // R10: the underrun flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

endmodule

bind lcd_src_timing lcd_src_timing_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .bck       (bck),
    .bsp       (bsp),
    .pix_bus   (pix_bus),
    .underrun  (underrun)
);

// File: tb/sim_lcd_src_timing.sv
module sim_lcd_src_timing;

    localparam int DATA_HP = 6;
    localparam int TAIL_HP = 4;
    localparam int GROUPS  = 3;
    localparam int HPG     = DATA_HP + TAIL_HP;
    localparam int NVEC    = (GROUPS - 1) * DATA_HP;

    // {stream byte, expected bus value}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF3F, 16'h0000, 16'hC000, 16'h2A2A, 16'h1515, 16'h0101,
        16'h2020, 16'h7E3E, 16'h8000, 16'h5515, 16'hAA2A, 16'h3F3F
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic       pix_ready, bck, bsp, underrun;
    logic [5:0] pix_bus;

    always #10 clk = ~clk;

    lcd_src_timing #(
        .DATA_HP (DATA_HP),
        .TAIL_HP (TAIL_HP),
        .GROUPS  (GROUPS),
        .PIX_W   (6),
        .BYTE_W  (8)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .bck       (bck),
        .bsp       (bsp),
        .pix_bus   (pix_bus),
        .underrun  (underrun)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int tick_cnt = 0, t0 = 0, idx = 0, ready_cnt = 0, xfer_cnt = 0;
    int hp_seen = 0, bsp_rises = 0, last_edge_tick = 0, bsp_rise_tick = 0;
    logic       prev_bck = 1'b0, prev_bsp = 1'b0;
    logic [5:0] prev_bus = 6'd0;
    logic want_start = 1'b0, want_quiet_start = 1'b0, want_rst = 1'b1;
    logic valid_en = 1'b0, chk_timing = 1'b0, mon_en = 1'b0, tick_phase = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic monitor();
        int g, k, exp;
        string lbl;
        if (bck != prev_bck) begin
            hp_seen++;
            if (chk_timing) begin
                if (hp_seen == 1)
                    check(tick_cnt - t0 == 4, "R2 first BCK rise tick", tick_cnt - t0, 4);
                else
                    check(tick_cnt - last_edge_tick == 4, "R3/R7 half-period length",
                          tick_cnt - last_edge_tick, 4);
            end
            last_edge_tick = tick_cnt;
            g = (hp_seen - 1) / HPG;
            k = (hp_seen - 1) % HPG + 1;
            check(bck == k[0], "R3 BCK level per half-period", bck, k[0]);
            if (g < GROUPS - 1 && k <= DATA_HP) begin
                exp = VEC[g * DATA_HP + k - 1][5:0];
                lbl = "R5 data half-period value";
            end else begin
                exp = 0;
                lbl = (g >= GROUPS - 1) ? "R8 closing group zero" : "R6 tail zero";
            end
            check(pix_bus == exp[5:0], lbl, pix_bus, exp);
        end else if (pix_bus != prev_bus) begin
            check(1'b0, "R5 bus moved without BCK edge", pix_bus, prev_bus);
        end
        if (bsp && !prev_bsp) begin
            bsp_rises++;
            bsp_rise_tick = tick_cnt;
            check(!bck, "R4 BSP rises with BCK low", bck, 0);
            if (chk_timing)
                check(tick_cnt - t0 == 2 + (bsp_rises - 1) * HPG * 4,
                      (bsp_rises == 1) ? "R2 BSP rise tick" : "R7 next group BSP tick",
                      tick_cnt - t0, 2 + (bsp_rises - 1) * HPG * 4);
        end
        if (!bsp && prev_bsp && chk_timing)
            check(tick_cnt - bsp_rise_tick == 8, "R4 BSP width in ticks",
                  tick_cnt - bsp_rise_tick, 8);
    endtask

    task automatic cycle();
        @(negedge clk);
        if (mon_en) monitor();
        prev_bck = bck;
        prev_bsp = bsp;
        prev_bus = pix_bus;
        rst   = want_rst;
        start = want_start | want_quiet_start;
        tick_phase = ~tick_phase;
        tick = tick_phase;
        if (tick) tick_cnt++;
        if (want_start) begin
            t0 = tick_cnt;
            hp_seen = 0; bsp_rises = 0; idx = 0; ready_cnt = 0; xfer_cnt = 0;
        end
        want_start = 1'b0;
        want_quiet_start = 1'b0;
        pix_valid = valid_en;
        pix_data  = (idx < NVEC) ? VEC[idx][15:8] : 8'hEE;
        #1;
        if (pix_ready) ready_cnt++;
        if (pix_ready && pix_valid) begin
            xfer_cnt++;
            idx++;
        end
    endtask

    task automatic frame_totals(input string tag);
        check(bsp_rises == GROUPS, {tag, " BSP rises per frame"}, bsp_rises, GROUPS);
        check(hp_seen == GROUPS * HPG, {tag, " BCK edges per frame"}, hp_seen, GROUPS * HPG);
        check(xfer_cnt == NVEC, {tag, " bytes accepted"}, xfer_cnt, NVEC);
    endtask

    initial begin
        #4_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R1)
        want_rst = 1'b1;
        repeat (3) cycle();
        want_rst = 1'b0;
        valid_en = 1'b1;
        repeat (12) begin
            cycle();
            check(pix_ready == 1'b0, "R1 no request before start", pix_ready, 0);
        end
        check(bck == 1'b0, "R1 BCK low", bck, 0);
        check(bsp == 1'b0, "R1 BSP low", bsp, 0);
        check(pix_bus == 6'd0, "R1 bus low", pix_bus, 0);
        check(underrun == 1'b0, "R1 underrun clear", underrun, 0);

        // Full frame walked through the vector table (R2..R9)
        mon_en = 1'b1;
        chk_timing = 1'b1;
        want_start = 1'b1;
        cycle();
        repeat (60) cycle();
        want_quiet_start = 1'b1;   // R9: ignored during a frame
        cycle();
        repeat (260) cycle();
        frame_totals("R8");
        check(ready_cnt == NVEC, "R8 requests per frame", ready_cnt, NVEC);
        check(bck == 1'b0 && bsp == 1'b0, "R9 controls low after frame", {bck, bsp}, 0);
        check(pix_bus == 6'd0, "R9 bus low after frame", pix_bus, 0);
        check(underrun == 1'b0, "R10 no underrun with full stream", underrun, 0);
        repeat (30) cycle();
        check(hp_seen == GROUPS * HPG, "R9 idle until next start", hp_seen, GROUPS * HPG);

        // Stall on an empty stream (R10)
        chk_timing = 1'b0;
        valid_en = 1'b0;
        want_start = 1'b1;
        cycle();
        repeat (14) cycle();
        check(bsp == 1'b1, "R10 BSP held during stall", bsp, 1);
        check(bck == 1'b0, "R10 BCK held during stall", bck, 0);
        check(hp_seen == 0, "R10 no half-period advance", hp_seen, 0);
        check(underrun == 1'b1, "R10 underrun set", underrun, 1);
        valid_en = 1'b1;
        repeat (280) cycle();
        frame_totals("R10");
        check(underrun == 1'b1, "R10 underrun sticky", underrun, 1);

        // Reset partway through a frame, then re-arm (R11)
        chk_timing = 1'b1;
        want_start = 1'b1;
        cycle();
        repeat (50) cycle();
        mon_en = 1'b0;
        want_rst = 1'b1;
        cycle();
        want_rst = 1'b0;
        cycle();
        check(bck == 1'b0 && bsp == 1'b0, "R11 controls low after reset", {bck, bsp}, 0);
        check(pix_bus == 6'd0, "R11 bus low after reset", pix_bus, 0);
        check(underrun == 1'b0, "R11 underrun cleared", underrun, 0);
        repeat (20) cycle();
        check(bck == 1'b0 && bsp == 1'b0, "R11 stays idle after reset", {bck, bsp}, 0);
        mon_en = 1'b1;
        want_start = 1'b1;
        cycle();
        repeat (280) cycle();
        frame_totals("R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule